// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel with Two Match Points

This block is a single timer channel. Once enabled it counts down from a programmed reload value, taking one step for each accepted tick pulse. When the count reaches zero, the next tick brings it back to the reload value. A control input chooses which pulse stream is counted: a slow external tick (nominally 1 MHz) or a tick derived from the bus clock. A four-word register port gives access to the live count, the reload value and two compare values. The two compare values need not be written in any particular order.

An event is raised when a decrement lands on either compare value. An event is also raised when a decrement lands on zero, provided the overflow enable is set or one of the compare points sits at zero. A compare value that is not below the reload value is treated as a compare at zero. Each event inverts a level-style interrupt output and pulses a one-cycle strobe, which a shared status register can collect. Bus decoding, sequencing of a shared control word and pulse-waveform generation are handled outside this block.

Top module: `dmt_channel`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, every register reads 0, `irq_level` is 0 and `irq_event` is 0.
- R2: `reg_addr` selects the word. 0 is the count, 1 is reload, 2 is compare A and 3 is compare B. A write to addresses 1 to 3 is visible on `reg_rdata` from the next cycle.
- R3: When `ext_sel` is 1 only `tick_ext` is counted. When `ext_sel` is 0 only `tick_bus` is counted. The unselected tick has no effect on the count.
- R4: On the first cycle `enable` is sampled high after being low, the count is loaded with the reload value and any tick in that cycle is not counted. While `enable` is low, address 0 reads 0.
- R5: While running with a nonzero reload, each accepted tick lowers the count by one. A tick at count 0 reloads the count and produces no event.
- R6: With reload equal to 0, ticks leave the count at 0. Writing a nonzero reload while running with a zero reload loads that value into the count on the next cycle.
- R7: A write to address 0 while running puts the written value into the count. A tick in the same cycle is dropped and gives no event.
- R8: A decrement whose new value equals compare A or compare B, in either programming order, gives exactly one event. When A and B are equal it still gives one event.
- R9: A compare value greater than or equal to the current reload acts as a compare at 0.
- R10: A decrement to 0 gives an event when `ovf_en` is 1 or when either effective compare is 0. Otherwise it gives no event.
- R11: Each event drives `irq_event` high for one cycle and toggles `irq_level` on the same clock edge that updates the count. `irq_level` never changes without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel run control |
| ext_sel | input | 1 | 1 counts the external tick, 0 counts the bus tick |
| ovf_en | input | 1 | Allows an event when the count reaches zero |
| tick_ext | input | 1 | External slow tick pulse |
| tick_bus | input | 1 | Bus-clock tick pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr` |
| irq_level | output | 1 | Interrupt level; inverts on each event |
| irq_event | output | 1 | One-cycle event strobe |

## Verification
Some cases are hard to reach from the ports because they need several things to line up in one cycle. One is a tick that coincides with a count write. Another is a zero-valued reload that is replaced by a nonzero one while running. A third is a compare value that becomes "at zero" only because the reload was lowered after the compare was written. Directed sequences set up each of these on purpose. After that, a long stretch of seeded random stimulus runs with small reload and compare values, so wraps, coinciding compares and same-cycle writes occur often. A cycle model in the bench predicts the count, the strobe and the level for every cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_MATCH_A = 2'd2,
        SEL_MATCH_B = 2'd3
    } dmt_sel_e;

    typedef struct packed {
        logic hit_a;
        logic hit_b;
        logic hit_zero;
    } dmt_hit_t;

    function automatic logic pick_tick(input logic ext_sel, input logic t_ext, input logic t_bus);
        return ext_sel ? t_ext : t_bus;
    endfunction

endpackage

// File: rtl/dmt_cfg.sv
module dmt_cfg
    import dmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  dmt_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] reload,
    output logic [W-1:0] match_a,
    output logic [W-1:0] match_b,
    output logic         start_ld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload  <= '0;
            match_a <= '0;
            match_b <= '0;
        end else if (wr) begin
            case (sel)
                SEL_RELOAD:  reload  <= wdata;
                SEL_MATCH_A: match_a <= wdata;
                SEL_MATCH_B: match_b <= wdata;
                default: ;
            endcase
        end
    end

    // nonzero reload replacing a zero one may kick a running counter
    assign start_ld = wr && (sel == SEL_RELOAD) && (reload == '0) && (wdata != '0);

    assert_reload_wr_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_RELOAD) |=> (reload == $past(wdata)));

    assert_match_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(match_a) && $stable(match_b) && $stable(reload)));

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         tick,
    input  logic         wr_count,
    input  logic         start_ld,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         running,
    output logic         step,
    output logic [W-1:0] dec_val
);

    logic en_q;
    logic arm;

    assign running = enable && en_q;
    assign arm     = enable && !en_q;
    assign dec_val = count - 1'b1;
    assign step    = running && !wr_count && !start_ld && tick
                     && (reload != '0) && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            count <= '0;
        end else begin
            en_q <= enable;
            if (arm) begin
                count <= reload;
            end else if (running && wr_count) begin
                count <= wdata;
            end else if (running && start_ld) begin
                count <= wdata;
            end else if (running && tick && reload != '0) begin
                count <= (count == '0) ? reload : dec_val;
            end
        end
    end

    assert_enable_load_R4: assert property (@(posedge clk) disable iff (rst)
        arm |=> (count == $past(reload)));

    assert_count_write_R7: assert property (@(posedge clk) disable iff (rst)
        (running && wr_count) |=> (count == $past(wdata)));

    assert_zero_reload_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (running && reload == '0 && !wr_count && !start_ld) |=> $stable(count));

    assert_frozen_off_R4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(count));

endmodule

// File: rtl/dmt_event.sv
module dmt_event
    import dmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] dec_val,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] match_a,
    input  logic [W-1:0] match_b,
    input  logic         ovf_en,
    output logic         irq_level,
    output logic         irq_event
);

    logic [W-1:0] eff_a;
    logic [W-1:0] eff_b;
    dmt_hit_t     hit;
    logic         fire;

    // a compare at or above reload is folded onto zero
    assign eff_a = (match_a < reload) ? match_a : '0;
    assign eff_b = (match_b < reload) ? match_b : '0;

    always_comb begin
        hit.hit_a    = (dec_val == eff_a);
        hit.hit_b    = (dec_val == eff_b);
        hit.hit_zero = (dec_val == '0) && ovf_en;
    end

    assign fire = step && (|hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_level <= 1'b0;
            irq_event <= 1'b0;
        end else begin
            irq_event <= fire;
            if (fire) irq_level <= !irq_level;
        end
    end

    assert_event_toggles_R11: assert property (@(posedge clk) disable iff (rst)
        irq_event |-> (irq_level != $past(irq_level)));

    assert_level_needs_event_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_level != $past(irq_level)) |-> irq_event);

    assert_zero_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (step && dec_val == '0 && !ovf_en && match_a != '0 && match_b != '0
         && match_a < reload && match_b < reload) |=> !irq_event);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> !irq_event);

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
    import dmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         ext_sel,
    input  logic         ovf_en,
    input  logic         tick_ext,
    input  logic         tick_bus,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         irq_level,
    output logic         irq_event
);

    dmt_sel_e     sel;
    logic [W-1:0] reload;
    logic [W-1:0] match_a;
    logic [W-1:0] match_b;
    logic [W-1:0] count;
    logic [W-1:0] dec_val;
    logic         start_ld;
    logic         running;
    logic         step;
    logic         tick;
    logic         wr_count;

    assign sel      = dmt_sel_e'(reg_addr);
    assign tick     = pick_tick(ext_sel, tick_ext, tick_bus);
    assign wr_count = reg_wr && (sel == SEL_COUNT);

    dmt_cfg #(.W(W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (sel),
        .wdata    (reg_wdata),
        .reload   (reload),
        .match_a  (match_a),
        .match_b  (match_b),
        .start_ld (start_ld)
    );

    dmt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .tick     (tick),
        .wr_count (wr_count),
        .start_ld (start_ld),
        .wdata    (reg_wdata),
        .reload   (reload),
        .count    (count),
        .running  (running),
        .step     (step),
        .dec_val  (dec_val)
    );

    dmt_event #(.W(W)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .dec_val   (dec_val),
        .reload    (reload),
        .match_a   (match_a),
        .match_b   (match_b),
        .ovf_en    (ovf_en),
        .irq_level (irq_level),
        .irq_event (irq_event)
    );

    always_comb begin
        case (sel)
            SEL_COUNT:   reg_rdata = running ? count : '0;
            SEL_RELOAD:  reg_rdata = reload;
            SEL_MATCH_A: reg_rdata = match_a;
            default:     reg_rdata = match_b;
        endcase
    end

endmodule

// File: tb/sim_dmt_channel.sv
module sim_dmt_channel;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst, enable, ext_sel, ovf_en, tick_ext, tick_bus, reg_wr;
    logic [1:0]   reg_addr;
    logic [W-1:0] reg_wdata, reg_rdata;
    logic         irq_level, irq_event;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    logic [W-1:0] m_cnt, m_rel, m_ma, m_mb;
    logic         m_enq, m_lvl, m_ev;

    always #5 clk = ~clk;

    dmt_channel #(.W(W)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .ext_sel(ext_sel), .ovf_en(ovf_en),
        .tick_ext(tick_ext), .tick_bus(tick_bus), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level),
        .irq_event(irq_event)
    );

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return (enable && m_enq) ? m_cnt : '0;
            2'd1: return m_rel;
            2'd2: return m_ma;
            default: return m_mb;
        endcase
    endfunction

    // model of one clock edge, built from the requirements
    task automatic model_edge();
        logic tk, run;
        logic [W-1:0] d, ea, eb;
        tk  = ext_sel ? tick_ext : tick_bus;
        run = enable && m_enq;
        m_ev = 1'b0;
        if (enable && !m_enq) m_cnt = m_rel;
        else if (run && reg_wr && reg_addr == 2'd0) m_cnt = reg_wdata;
        else if (run && reg_wr && reg_addr == 2'd1 && m_rel == 0 && reg_wdata != 0) m_cnt = reg_wdata;
        else if (run && tk && m_rel != 0) begin
            if (m_cnt == 0) m_cnt = m_rel;
            else begin
                d  = m_cnt - 1;
                ea = (m_ma < m_rel) ? m_ma : '0;
                eb = (m_mb < m_rel) ? m_mb : '0;
                m_ev = (d == ea) || (d == eb) || (d == 0 && ovf_en);
                m_cnt = d;
            end
        end
        if (reg_wr) begin
            case (reg_addr)
                2'd1: m_rel = reg_wdata;
                2'd2: m_ma  = reg_wdata;
                2'd3: m_mb  = reg_wdata;
                default: ;
            endcase
        end
        m_enq = enable;
        if (m_ev) m_lvl = !m_lvl;
    endtask

    // called at a negedge with inputs set; returns at the next negedge
    task automatic cyc();
        model_edge();
        @(posedge clk);
        #2;
        check(cur_req, "rdata", reg_rdata, m_read(reg_addr));
        check(cur_req == "R1" ? "R11" : cur_req, "irq_event", W'(irq_event), W'(m_ev));
        check(cur_req == "R1" ? "R11" : cur_req, "irq_level", W'(irq_level), W'(m_lvl));
        @(negedge clk);
        reg_wr = 1'b0; tick_ext = 1'b0; tick_bus = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            if (ext_sel) tick_ext = 1'b1; else tick_bus = 1'b1;
            cyc();
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; enable = 0; ext_sel = 0; ovf_en = 0; tick_ext = 0; tick_bus = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        m_cnt = '0; m_rel = '0; m_ma = '0; m_mb = '0; m_enq = 0; m_lvl = 0; m_ev = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a); #1;
            check("R1", "reset read", reg_rdata, '0);
        end
        check("R1", "reset level", W'(irq_level), '0);
        rst = 1'b0; reg_addr = 2'd0;
        cyc();

        // R2: register map readback
        cur_req = "R2";
        wr(2'd1, 32'd10); wr(2'd2, 32'd3); wr(2'd3, 32'd7);
        reg_addr = 2'd1; #1; check("R2", "reload rb", reg_rdata, 32'd10);
        reg_addr = 2'd2; #1; check("R2", "matchA rb", reg_rdata, 32'd3);
        reg_addr = 2'd3; #1; check("R2", "matchB rb", reg_rdata, 32'd7);
        reg_addr = 2'd0; #1; check("R4", "disabled read", reg_rdata, '0);

        // R4: enable loads reload, tick in that cycle dropped
        cur_req = "R4";
        enable = 1'b1; tick_bus = 1'b1; cyc();
        check("R4", "load on enable", reg_rdata, 32'd10);

        // R3: unselected tick has no effect
        cur_req = "R3";
        ext_sel = 1'b1;
        tick_bus = 1'b1; cyc(); tick_bus = 1'b1; cyc();
        check("R3", "bus tick ignored", reg_rdata, 32'd10);
        tick_ext = 1'b1; cyc();
        check("R3", "ext tick counted", reg_rdata, 32'd9);

        // R8/R5: B=7 then A=3, then zero with ovf off (no event) and wrap
        cur_req = "R8";
        ticks(2);
        check("R8", "event at B", W'(irq_event), 1);
        ticks(4);
        check("R8", "event at A", W'(irq_event), 1);
        cur_req = "R10";
        ticks(3);
        check("R10", "no zero event", W'(irq_event), 0);
        cur_req = "R5";
        ticks(1);
        check("R5", "wrap to reload", reg_rdata, 32'd10);

        // R9: compare above reload acts at zero; R10 zero event
        cur_req = "R9";
        wr(2'd2, 32'd50);
        ticks(10);
        check("R9", "zero via high compare", W'(irq_event), 1);

        // R10: overflow enable with both compares nonzero
        cur_req = "R10";
        wr(2'd2, 32'd4); wr(2'd3, 32'd4); ovf_en = 1'b1;
        ticks(11);
        check("R10", "ovf zero event", W'(irq_event), 1);
        ovf_en = 1'b0;

        // R7: count write with coincident tick
        cur_req = "R7";
        tick_ext = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd5; cyc();
        check("R7", "written count wins", reg_rdata, 32'd5);
        ticks(1);
        check("R8", "equal compares one event", W'(irq_event), 1);

        // R6: zero reload idles; nonzero reload starts
        cur_req = "R6";
        enable = 1'b0; cyc();
        wr(2'd1, 32'd0);
        enable = 1'b1; cyc();
        ticks(3);
        check("R6", "idle at zero", reg_rdata, '0);
        wr(2'd1, 32'd6);
        check("R6", "start on reload", reg_rdata, 32'd6);

        // random mix
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 3) enable = !enable;
            if ($urandom_range(99) < 5) ext_sel = !ext_sel;
            if ($urandom_range(99) < 5) ovf_en = !ovf_en;
            tick_ext = 1'($urandom_range(1));
            tick_bus = 1'($urandom_range(1));
            reg_addr = 2'($urandom_range(3));
            if ($urandom_range(99) < 8) begin
                reg_wr = 1'b1;
                if (reg_addr == 2'd1 && $urandom_range(9) == 0) reg_wdata = '0;
                else reg_wdata = W'($urandom_range(24));
            end
            cyc();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule